// File: doc/BRIEF.md
# Compare-Triggered Conversion Start Sequencer

This block lets a timer compare event launch analog-to-digital conversions at a fixed rate without software. Two free-running 16-bit timers count on every clock. A configuration bit selects which of them the compare channel watches. When the compare mode field holds the special-event code and the selected timer reaches the compare value, the block produces a one-cycle trigger. That trigger always clears the selected timer, so the next event follows after exactly compare-plus-one counts. The trigger starts a conversion only if the converter is enabled and idle.

The converter is modelled as a handshake. The block raises a one-cycle start pulse and holds a busy (go/done) bit. At the same moment it presents the channel and acquisition-time settings that it sampled when the conversion started. When the converter returns a done pulse, the block captures the 10-bit result, clears go/done and sets a sticky interrupt flag. Software writes the mode, the compare value and a control word through a simple write port. A control write can also start a conversion directly.

Top module: `adc_evt_seq`

## Requirements
- R1: A trigger occurs only while the mode field (address 0, bits 3:0) holds 4'b1011. Every other mode value produces no trigger and no timer clear.
- R2: On a trigger with the converter enabled (control bit 0) and go/done clear, `conv_start` pulses high and `go_done` goes high. Both are visible in the cycle after the edge at which the selected timer equals the compare value (address 1).
- R3: The timers increment by one on every clock. A trigger clears the selected timer to zero at the match edge, so triggers repeat every compare value plus one cycles.
- R4: With the converter enable clear, a trigger starts no conversion but still clears the selected timer.
- R5: A trigger that arrives while `go_done` is high starts no new conversion. It still clears the timer.
- R6: A `conv_done` pulse while `go_done` is high has three effects on the next edge: `go_done` clears, `conv_data` is latched into `result_q`, and `irq_flag` is set.
- R7: `irq_flag` stays set until a control write with bit 3 equal to 0. If a done pulse and such a write occur on the same edge, the flag is set.
- R8: Control bit 2 selects the timer that is compared and cleared (0: timer 0, 1: timer 1). The other timer keeps counting undisturbed.
- R9: The channel (control bits 7:4) and acquisition time (control bits 10:8) are sampled onto `conv_chan`/`conv_acq` when a conversion starts. They hold until the next start.
- R10: A control write with bits 1 and 0 both set starts a conversion on that edge if `go_done` is clear.
- R11: Reset clears both timers, `go_done`, `irq_flag`, `result_q`, `conv_start` and `trig_pulse`. Configuration writes are accepted while reset is asserted.
- R12: A `conv_done` pulse while `go_done` is low changes neither `result_q` nor `irq_flag`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | 0 mode, 1 compare value, 2 control |
| wr_data | input | 16 | Write data |
| conv_done | input | 1 | Converter completion pulse |
| conv_data | input | 10 | Converter result, valid with conv_done |
| conv_start | output | 1 | One-cycle conversion start pulse |
| conv_chan | output | 4 | Channel sampled at start |
| conv_acq | output | 3 | Acquisition time sampled at start |
| go_done | output | 1 | Conversion in progress |
| irq_flag | output | 1 | Sticky completion flag |
| result_q | output | 10 | Last captured result |
| trig_pulse | output | 1 | Registered special-event trigger |
| timer0_q | output | 16 | Timer 0 count |
| timer1_q | output | 16 | Timer 1 count |

## Verification
A corrupted timer or compare decode appears on the timer port within one cycle, as a count that fails to restart from zero. It also appears as a trigger spacing other than compare plus one, and the bench sees that within one period. A stuck or lost go/done bit appears the next time a trigger arrives. In that case a start pulse shows up while the converter is busy, or no start pulse shows up when it is idle. A wrong result or flag path appears on the cycle after the done pulse, and the bench samples exactly there.

// File: rtl/evt_pkg.sv
package evt_pkg;
  localparam logic [3:0] MODE_EVT = 4'b1011;

  typedef enum logic [1:0] {
    ADDR_MODE = 2'd0,
    ADDR_CMP  = 2'd1,
    ADDR_CTRL = 2'd2
  } reg_addr_e;

  localparam int CTL_EN    = 0;
  localparam int CTL_GO    = 1;
  localparam int CTL_SEL   = 2;
  localparam int CTL_FLAG  = 3;
  localparam int CTL_CHAN0 = 4;
  localparam int CTL_ACQ0  = 8;
endpackage

// File: rtl/evt_timer.sv
module evt_timer #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)      q <= '0;
    else if (clr) q <= '0;
    else          q <= q + 1'b1;
  end

  AST_TIMER_STEP: assert property (@(posedge clk) disable iff (rst)
    !$past(clr) && !$past(rst) |-> q == $past(q) + 1'b1); // R3
  AST_TIMER_CLEAR: assert property (@(posedge clk) disable iff (rst)
    $past(clr) |-> q == '0); // R3
endmodule

// File: rtl/evt_match.sv
module evt_match
  import evt_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [3:0]   mode,
  input  logic [W-1:0] cmp,
  input  logic [W-1:0] tmr_a,
  input  logic [W-1:0] tmr_b,
  input  logic         sel,
  output logic         hit,
  output logic         trig_q
);
  logic [W-1:0] tmr_sel;

  always_comb begin
    tmr_sel = sel ? tmr_b : tmr_a;
    hit     = !rst && (mode == MODE_EVT) && (tmr_sel == cmp);
  end

  always_ff @(posedge clk) begin
    if (rst) trig_q <= 1'b0;
    else     trig_q <= hit;
  end

  AST_TRIG_MODE: assert property (@(posedge clk) disable iff (rst)
    trig_q |-> $past(mode) == MODE_EVT); // R1
endmodule

// File: rtl/conv_ctrl.sv
module conv_ctrl #(
  parameter int RW = 10,
  parameter int CW = 4,
  parameter int AW = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          trig,
  input  logic          en,
  input  logic          sw_go,
  input  logic          flag_clr,
  input  logic [CW-1:0] chan_d,
  input  logic [AW-1:0] acq_d,
  input  logic          conv_done,
  input  logic [RW-1:0] conv_data,
  output logic          conv_start,
  output logic          go_done,
  output logic [CW-1:0] conv_chan,
  output logic [AW-1:0] conv_acq,
  output logic [RW-1:0] result_q,
  output logic          irq_flag
);
  logic start_req;
  logic done_acc;

  always_comb begin
    start_req = !go_done && ((trig && en) || sw_go);
    done_acc  = go_done && conv_done;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      go_done    <= 1'b0;
      conv_start <= 1'b0;
      result_q   <= '0;
      irq_flag   <= 1'b0;
      conv_chan  <= '0;
      conv_acq   <= '0;
    end else begin
      conv_start <= start_req;
      if (done_acc)       go_done <= 1'b0;
      else if (start_req) go_done <= 1'b1;
      if (start_req) begin
        conv_chan <= chan_d;
        conv_acq  <= acq_d;
      end
      if (done_acc) result_q <= conv_data;
      if (done_acc)      irq_flag <= 1'b1;
      else if (flag_clr) irq_flag <= 1'b0;
    end
  end

  AST_BUSY_NO_START: assert property (@(posedge clk) disable iff (rst)
    conv_start |-> !$past(go_done)); // R5
  AST_START_SETS_GO: assert property (@(posedge clk) disable iff (rst)
    conv_start |-> go_done); // R2
  AST_GO_HOLD: assert property (@(posedge clk) disable iff (rst)
    go_done && !conv_done |=> go_done); // R6
  AST_DONE_FLAG: assert property (@(posedge clk) disable iff (rst)
    go_done && conv_done |=> !go_done && irq_flag); // R6
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
    irq_flag && !flag_clr |=> irq_flag); // R7
  AST_IDLE_DONE: assert property (@(posedge clk) disable iff (rst)
    !go_done && conv_done |=> $stable(result_q)); // R12
endmodule

// File: rtl/adc_evt_seq.sv
module adc_evt_seq
  import evt_pkg::*;
#(
  parameter int TW = 16,
  parameter int RW = 10,
  parameter int CW = 4,
  parameter int AW = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [1:0]    wr_addr,
  input  logic [15:0]   wr_data,
  input  logic          conv_done,
  input  logic [RW-1:0] conv_data,
  output logic          conv_start,
  output logic [CW-1:0] conv_chan,
  output logic [AW-1:0] conv_acq,
  output logic          go_done,
  output logic          irq_flag,
  output logic [RW-1:0] result_q,
  output logic          trig_pulse,
  output logic [TW-1:0] timer0_q,
  output logic [TW-1:0] timer1_q
);
  localparam int NT = 2;

  logic [3:0]    mode_r;
  logic [TW-1:0] cmp_r;
  logic          en_r;
  logic          sel_r;
  logic [CW-1:0] chan_r;
  logic [AW-1:0] acq_r;

  logic          wr_mode, wr_cmp, wr_ctl;
  logic          hit, sw_go, flag_clr;
  logic [CW-1:0] chan_d;
  logic [AW-1:0] acq_d;
  logic [TW-1:0] tmr_q [NT];
  logic [NT-1:0] tmr_clr;

  always_comb begin
    wr_mode  = wr_en && (wr_addr == ADDR_MODE);
    wr_cmp   = wr_en && (wr_addr == ADDR_CMP);
    wr_ctl   = wr_en && (wr_addr == ADDR_CTRL);
    sw_go    = wr_ctl && wr_data[CTL_GO] && wr_data[CTL_EN];
    flag_clr = wr_ctl && !wr_data[CTL_FLAG];
    chan_d   = wr_ctl ? wr_data[CTL_CHAN0 +: CW] : chan_r;
    acq_d    = wr_ctl ? wr_data[CTL_ACQ0 +: AW]  : acq_r;
  end

  // configuration is kept across reset and writable during it
  always_ff @(posedge clk) begin
    if (wr_mode) mode_r <= wr_data[3:0];
    if (wr_cmp)  cmp_r  <= wr_data[TW-1:0];
    if (wr_ctl) begin
      en_r   <= wr_data[CTL_EN];
      sel_r  <= wr_data[CTL_SEL];
      chan_r <= wr_data[CTL_CHAN0 +: CW];
      acq_r  <= wr_data[CTL_ACQ0 +: AW];
    end
  end

  for (genvar i = 0; i < NT; i++) begin : g_tmr
    assign tmr_clr[i] = hit && (sel_r == 1'(i));
    evt_timer #(.W(TW)) tmr_i (
      .clk (clk),
      .rst (rst),
      .clr (tmr_clr[i]),
      .q   (tmr_q[i])
    );
  end

  assign timer0_q = tmr_q[0];
  assign timer1_q = tmr_q[1];

  evt_match #(.W(TW)) match_i (
    .clk    (clk),
    .rst    (rst),
    .mode   (mode_r),
    .cmp    (cmp_r),
    .tmr_a  (tmr_q[0]),
    .tmr_b  (tmr_q[1]),
    .sel    (sel_r),
    .hit    (hit),
    .trig_q (trig_pulse)
  );

  conv_ctrl #(.RW(RW), .CW(CW), .AW(AW)) ctrl_i (
    .clk        (clk),
    .rst        (rst),
    .trig       (hit),
    .en         (en_r),
    .sw_go      (sw_go),
    .flag_clr   (flag_clr),
    .chan_d     (chan_d),
    .acq_d      (acq_d),
    .conv_done  (conv_done),
    .conv_data  (conv_data),
    .conv_start (conv_start),
    .go_done    (go_done),
    .conv_chan  (conv_chan),
    .conv_acq   (conv_acq),
    .result_q   (result_q),
    .irq_flag   (irq_flag)
  );

  AST_TRIG_CLEARS: assert property (@(posedge clk) disable iff (rst)
    trig_pulse |-> (($past(sel_r) ? timer1_q : timer0_q) == '0)); // R3
  AST_NO_TRIG_NO_START: assert property (@(posedge clk) disable iff (rst)
    conv_start && !trig_pulse |-> $past(sw_go)); // R10
endmodule

// File: tb/adc_evt_seq_tb.sv
module adc_evt_seq_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic        conv_done = 1'b0;
  logic [9:0]  conv_data = '0;
  logic        conv_start, go_done, irq_flag, trig_pulse;
  logic [3:0]  conv_chan;
  logic [2:0]  conv_acq;
  logic [9:0]  result_q;
  logic [15:0] timer0_q, timer1_q;
  logic        auto_done = 1'b0;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;
  bit over = 1'b0;

  always #5 clk = ~clk;

  adc_evt_seq dut_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .conv_done(conv_done), .conv_data(conv_data), .conv_start(conv_start),
    .conv_chan(conv_chan), .conv_acq(conv_acq), .go_done(go_done),
    .irq_flag(irq_flag), .result_q(result_q), .trig_pulse(trig_pulse),
    .timer0_q(timer0_q), .timer1_q(timer1_q)
  );

  // converter model: answers one cycle after each start
  always @(negedge clk) begin
    if (auto_done) begin
      conv_done = conv_start;
      conv_data = 10'h155;
    end
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000 && !over) begin
      over = 1'b1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: run did not finish, act=%0d exp<150000", cyc);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wait_trig();
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      if (trig_pulse) return;
    end
    chk(1'b0, "wait for trigger", 0, 1);
  endtask

  function automatic logic [15:0] ctl(input bit en, input bit go, input bit sel,
                                      input bit keep, input int ch, input int aq);
    return 16'(en) | (16'(go) << 1) | (16'(sel) << 2) | (16'(keep) << 3)
           | (16'(ch & 15) << 4) | (16'(aq & 7) << 8);
  endfunction

  localparam int NV = 7;
  localparam int V_MODE [NV] = '{11, 11, 10, 11, 15, 11, 3};
  localparam int V_CMP  [NV] = '{9, 3, 5, 0, 2, 1, 1};
  localparam int V_EN   [NV] = '{1, 0, 1, 1, 1, 1, 1};
  localparam int V_SEL  [NV] = '{0, 1, 0, 0, 1, 1, 0};
  localparam int V_WIN  [NV] = '{40, 16, 40, 8, 40, 8, 20};
  localparam int V_TRG  [NV] = '{4, 4, 0, 8, 0, 4, 0};
  localparam int V_STR  [NV] = '{4, 0, 0, 4, 0, 4, 0};

  initial begin
    // vector table: R1 mode gating, R3 period, R4 enable, R5 busy, R8 select
    auto_done = 1'b1;
    for (int v = 0; v < NV; v++) begin
      int trg, str;
      @(negedge clk); rst = 1'b1;
      wr(2'd0, 16'(V_MODE[v]));
      wr(2'd1, 16'(V_CMP[v]));
      wr(2'd2, ctl(V_EN[v] != 0, 1'b0, V_SEL[v] != 0, 1'b1, 0, 0));
      rst = 1'b0;
      if (V_TRG[v] > 0) wait_trig();
      trg = 0; str = 0;
      for (int c = 0; c < V_WIN[v]; c++) begin
        @(negedge clk);
        trg += int'(trig_pulse);
        str += int'(conv_start);
      end
      chk(trg == V_TRG[v], $sformatf("R1/R3/R8 vec%0d trigger count", v), trg, V_TRG[v]);
      chk(str == V_STR[v], $sformatf("R4/R5 vec%0d start count", v), str, V_STR[v]);
    end
    auto_done = 1'b0;
    conv_done = 1'b0;

    // R11: reset state, config writes during reset
    @(negedge clk); rst = 1'b1;
    wr(2'd1, 16'd5);
    wr(2'd2, ctl(1'b0, 1'b0, 1'b0, 1'b1, 0, 0));
    wr(2'd0, 16'd11);
    chk(timer0_q == 0 && timer1_q == 0, "R11 timers zero", timer0_q, 0);
    chk(!go_done && !irq_flag && !conv_start && !trig_pulse, "R11 status low",
        {go_done, irq_flag, conv_start, trig_pulse}, 0);
    chk(result_q == 0, "R11 result zero", result_q, 0);
    rst = 1'b0;

    // R3/R8/R4: clear of selected timer, other free-runs, no start when disabled
    wait_trig();
    chk(timer0_q == 0, "R3 selected timer cleared", timer0_q, 0);
    chk(timer1_q == 6, "R8 other timer free-runs", timer1_q, 6);
    chk(!conv_start && !go_done, "R4 no start while disabled", conv_start, 0);
    @(negedge clk);
    chk(timer0_q == 1, "R3 timer counts after clear", timer0_q, 1);

    // R2/R9: start on trigger with sampled settings
    wr(2'd2, ctl(1'b1, 1'b0, 1'b0, 1'b1, 9, 6));
    wait_trig();
    chk(conv_start && go_done, "R2 start and go_done", {conv_start, go_done}, 3);
    chk(conv_chan == 9 && conv_acq == 6, "R9 settings sampled",
        {conv_chan, conv_acq}, {4'd9, 3'd6});
    wr(2'd2, ctl(1'b1, 1'b0, 1'b0, 1'b1, 2, 1));
    chk(conv_chan == 9 && conv_acq == 6, "R9 settings held", {conv_chan, conv_acq},
        {4'd9, 3'd6});
    wait_trig();
    chk(!conv_start && go_done, "R5 busy blocks start", conv_start, 0);
    chk(timer0_q == 0, "R5 timer still cleared", timer0_q, 0);

    // R6: done completes conversion
    conv_done = 1'b1; conv_data = 10'h2A5;
    @(negedge clk);
    conv_done = 1'b0; conv_data = '0;
    chk(!go_done, "R6 go_done cleared", go_done, 0);
    chk(result_q == 10'h2A5, "R6 result latched", result_q, 10'h2A5);
    chk(irq_flag, "R6 flag set", irq_flag, 1);
    wr(2'd0, 16'd0);

    // R12: done while idle ignored
    conv_done = 1'b1; conv_data = 10'h111;
    @(negedge clk);
    conv_done = 1'b0;
    chk(result_q == 10'h2A5, "R12 result unchanged", result_q, 10'h2A5);
    chk(irq_flag && !go_done, "R12 flag unchanged", irq_flag, 1);

    // R7: sticky flag, cleared only by a zero write
    repeat (4) @(negedge clk);
    chk(irq_flag, "R7 flag holds", irq_flag, 1);
    wr(2'd2, ctl(1'b0, 1'b0, 1'b0, 1'b1, 0, 0));
    chk(irq_flag, "R7 write one keeps flag", irq_flag, 1);
    wr(2'd2, ctl(1'b0, 1'b0, 1'b0, 1'b0, 0, 0));
    chk(!irq_flag, "R7 write zero clears flag", irq_flag, 0);

    // R10: software start
    wr(2'd2, ctl(1'b1, 1'b1, 1'b0, 1'b1, 4, 2));
    chk(conv_start && go_done, "R10 software start", {conv_start, go_done}, 3);
    chk(conv_chan == 4 && conv_acq == 2, "R9 settings at software start",
        {conv_chan, conv_acq}, {4'd4, 3'd2});
    @(negedge clk);
    chk(!conv_start && go_done, "R2 start is one cycle", conv_start, 0);

    // R7: done beats a simultaneous clear write
    conv_done = 1'b1; conv_data = 10'h03C;
    wr_en = 1'b1; wr_addr = 2'd2; wr_data = ctl(1'b1, 1'b0, 1'b0, 1'b0, 0, 0);
    @(negedge clk);
    conv_done = 1'b0; wr_en = 1'b0;
    chk(irq_flag, "R7 set wins over clear", irq_flag, 1);
    chk(result_q == 10'h03C, "R6 second result", result_q, 10'h03C);

    if (!over) begin
      over = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule